// File: doc/BRIEF.md
# NAND Card Command Decoder

This block sits on the card side of an 8-bit multiplexed NAND-style bus. It watches the host's strobes on its own clock and takes one byte from the shared data lines on each rising edge of the write strobe. The byte is a command when the command-select line is high, or an address when the address-select line is high. From these bytes it decodes three operations: a soft reset that also pulls the ready line low for a bounded time, an identification read, and a status read. While the host holds the read strobe low, it places the matching response byte on the bus.

For a set time after reset the block is in a recovery window, and it ignores every write during that window. Both the recovery window and the busy time are given as parameters in clock cycles. Their defaults come from the clock rate, and a bench can shorten them. All outputs are registered. The bus output enable goes high only for cycles in which the chip is selected, the read strobe is low, and a read mode is armed.

Top module: `nand_card_ctrl`

## Requirements
- R1: A byte on `bus_in` is latched on a rising edge of `wr_strobe_n`, sampled at a clock edge, only while `chip_sel_n` is low. It is a command when `cmd_sel` is high and `addr_sel` is low, and an address when `addr_sel` is high and `cmd_sel` is low. A write made while the chip is deselected has no effect.
- R2: For the first `PWRUP_CYC` clock edges after reset is released, every write is ignored. `ready` stays 1 and no read mode is armed.
- R3: Command FFh accepted while `ready` is 1 drives `ready` low for exactly `BUSY_CYC` cycles, starting with the cycle after the latching edge. A further FFh accepted while busy does not lengthen that time.
- R4: Command FFh returns the decoder to idle, so a read armed earlier no longer drives the bus.
- R5: Command 90h followed by address 00h arms an identification read. The first read strobe low returns ECh, the second returns `DEV_CODE`, and every later one returns 00h.
- R6: After 90h, any address other than 00h returns the decoder to idle and nothing is driven.
- R7: After command 70h, each read returns a status byte. Bit 7 equals `wr_lock_n`, bit 6 equals `ready`, and bits 5 to 0 are 0 (bit 0 is the pass/fail flag, always pass).
- R8: Any command byte other than FFh, 90h and 70h returns the decoder to idle and leaves `ready` unchanged.
- R9: `bus_drive` is 1 in the cycle after a clock edge that sees `chip_sel_n` low, `rd_strobe_n` low and a read mode armed, and 0 otherwise. `bus_out` is 00h whenever `bus_drive` is 0.
- R10: During and right after reset, `ready` is 1, `bus_drive` is 0 and `bus_out` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| chip_sel_n | input | 1 | Active-low chip select |
| cmd_sel | input | 1 | High: written byte is a command |
| addr_sel | input | 1 | High: written byte is an address |
| wr_strobe_n | input | 1 | Active-low write strobe; byte taken on its rising edge |
| rd_strobe_n | input | 1 | Active-low read strobe |
| wr_lock_n | input | 1 | Active-low write-protect input |
| bus_in | input | 8 | Data lines as seen by the card |
| bus_out | output | 8 | Response byte, 00h when not driving |
| bus_drive | output | 1 | Output enable for the data lines |
| ready | output | 1 | 1 ready, 0 busy |

## Verification
Status reads are taken with write-protect asserted and deasserted, and both while ready and while busy, so each status bit is shown to track its own input. The identification read uses the valid address, a wrong address, and more reads than there are ID bytes, which separates the arm step, the abort path and the byte sequence. The reset command is sent once alone and then a second time while the part is already busy, which tells a fixed busy window apart from one that restarts. Writes made during power-up, while deselected, and with unknown opcodes each confirm that the decoder state does not change.

// File: rtl/nand_cmd_pkg.sv
package nand_cmd_pkg;
   typedef enum logic [1:0] {
      MODE_IDLE    = 2'd0,
      MODE_ID_ADDR = 2'd1,
      MODE_ID_OUT  = 2'd2,
      MODE_STATUS  = 2'd3
   } mode_e;

   localparam logic [7:0] OP_RESET   = 8'hFF;
   localparam logic [7:0] OP_READ_ID = 8'h90;
   localparam logic [7:0] OP_STATUS  = 8'h70;
   localparam logic [7:0] ID_ADDR    = 8'h00;
   localparam logic [7:0] MAKER_BYTE = 8'hEC;

   // status: [7] not write-protected, [6] ready, [5:0] zero (pass)
   function automatic logic [7:0] status_byte(input logic rdy, input logic unlocked);
      return {unlocked, rdy, 6'b0};
   endfunction
endpackage

// File: rtl/nand_in_align.sv
module nand_in_align #(
   parameter int unsigned           W       = 14,
   parameter int unsigned           STAGES  = 0,
   parameter logic [W-1:0]          IDLE_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES > 4) begin : g_bad_stages
      $error("nand_in_align: STAGES above 4 not supported");
   end

   if (STAGES == 0) begin : g_direct
      assign q = d;
   end else begin : g_sync
      logic [W-1:0] pipe [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) pipe[i] <= IDLE_VAL;
         end else begin
            pipe[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) pipe[i] <= pipe[i-1];
         end
      end
      assign q = pipe[STAGES-1];
   end
endmodule

// File: rtl/nand_cycle_timer.sv
module nand_cycle_timer #(
   parameter int unsigned CYCLES     = 4,
   parameter bit          START_FULL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic idle
);
   localparam int unsigned   CW      = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
   localparam logic [CW-1:0] FULL    = CW'(CYCLES);
   localparam logic [CW-1:0] RST_VAL = START_FULL ? FULL : '0;

   if (CYCLES < 1) begin : g_bad_cycles
      $error("nand_cycle_timer: CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= RST_VAL;
      else if (load)          cnt <= FULL;
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign idle = (cnt == '0);
endmodule

// File: rtl/nand_card_ctrl.sv
module nand_card_ctrl
   import nand_cmd_pkg::*;
#(
   parameter int unsigned CLK_MHZ     = 250,
   parameter int unsigned PWRUP_NS    = 1000,
   parameter int unsigned BUSY_NS     = 5000,
   parameter int unsigned PWRUP_CYC   = (CLK_MHZ * PWRUP_NS) / 1000,
   parameter int unsigned BUSY_CYC    = (CLK_MHZ * BUSY_NS) / 1000,
   parameter int unsigned SYNC_STAGES = 0,
   parameter logic [7:0]  DEV_CODE    = 8'h75
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       chip_sel_n,
   input  logic       cmd_sel,
   input  logic       addr_sel,
   input  logic       wr_strobe_n,
   input  logic       rd_strobe_n,
   input  logic       wr_lock_n,
   input  logic [7:0] bus_in,
   output logic [7:0] bus_out,
   output logic       bus_drive,
   output logic       ready
);
   localparam int unsigned BW       = 14;
   localparam logic [BW-1:0] IDLE_B = {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00};
   localparam int unsigned ID_LAST  = 2;

   if (PWRUP_CYC < 1 || BUSY_CYC < 1) begin : g_bad_timing
      $error("nand_card_ctrl: timing parameters must be at least one cycle");
   end

   // aligned view of the pins
   logic [BW-1:0] raw_b, al_b;
   logic          s_cs_n, s_cmd, s_addr, s_wr_n, s_rd_n, s_lock_n;
   logic [7:0]    s_bus;

   assign raw_b = {chip_sel_n, cmd_sel, addr_sel, wr_strobe_n, rd_strobe_n, wr_lock_n, bus_in};

   nand_in_align #(.W(BW), .STAGES(SYNC_STAGES), .IDLE_VAL(IDLE_B)) u_align (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_b),
      .q     (al_b)
   );

   assign {s_cs_n, s_cmd, s_addr, s_wr_n, s_rd_n, s_lock_n, s_bus} = al_b;

   // strobe edge detection
   logic wr_q, rd_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q <= 1'b1;
         rd_q <= 1'b1;
      end else begin
         wr_q <= s_wr_n;
         rd_q <= s_rd_n;
      end
   end

   logic wr_rise, rd_rise, pwr_ok, accept, cmd_hit, addr_hit, busy_load;

   assign wr_rise = s_wr_n & ~wr_q;
   assign rd_rise = s_rd_n & ~rd_q;

   nand_cycle_timer #(.CYCLES(PWRUP_CYC), .START_FULL(1'b1)) u_pwrup (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (1'b0),
      .idle  (pwr_ok)
   );

   assign accept    = wr_rise & ~s_cs_n & pwr_ok;
   assign cmd_hit   = accept & s_cmd & ~s_addr;
   assign addr_hit  = accept & s_addr & ~s_cmd;
   assign busy_load = cmd_hit & (s_bus == OP_RESET) & ready;

   nand_cycle_timer #(.CYCLES(BUSY_CYC), .START_FULL(1'b0)) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (busy_load),
      .idle  (ready)
   );

   // command state
   mode_e      mode_q, mode_d;
   logic [1:0] id_idx;

   always_comb begin
      mode_d = mode_q;
      if (cmd_hit) begin
         unique case (s_bus)
            OP_READ_ID: mode_d = MODE_ID_ADDR;
            OP_STATUS:  mode_d = MODE_STATUS;
            default:    mode_d = MODE_IDLE;
         endcase
      end else if (addr_hit && mode_q == MODE_ID_ADDR) begin
         mode_d = (s_bus == ID_ADDR) ? MODE_ID_OUT : MODE_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_IDLE;
         id_idx <= '0;
      end else begin
         mode_q <= mode_d;
         if (addr_hit && mode_d == MODE_ID_OUT)
            id_idx <= '0;
         else if (rd_rise && !s_cs_n && mode_q == MODE_ID_OUT && id_idx != 2'(ID_LAST))
            id_idx <= id_idx + 1'b1;
      end
   end

   // response multiplexer, registered
   logic       read_on;
   logic [7:0] resp;

   assign read_on = ~s_cs_n & ~s_rd_n & (mode_q == MODE_STATUS || mode_q == MODE_ID_OUT);

   always_comb begin
      if (mode_q == MODE_STATUS)  resp = status_byte(ready, s_lock_n);
      else if (id_idx == 2'd0)    resp = MAKER_BYTE;
      else if (id_idx == 2'd1)    resp = DEV_CODE;
      else                        resp = 8'h00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_drive <= 1'b0;
         bus_out   <= 8'h00;
      end else begin
         bus_drive <= read_on;
         bus_out   <= read_on ? resp : 8'h00;
      end
   end
endmodule

// File: rtl/nand_card_ctrl_chk.sv
module nand_card_ctrl_chk #(
   parameter int unsigned PWRUP_CYC   = 250,
   parameter int unsigned BUSY_CYC    = 1250,
   parameter int unsigned SYNC_STAGES = 0
) (
   input logic       clk,
   input logic       rst_n,
   input logic       chip_sel_n,
   input logic       cmd_sel,
   input logic       wr_strobe_n,
   input logic       rd_strobe_n,
   input logic [7:0] bus_in,
   input logic [7:0] bus_out,
   input logic       bus_drive,
   input logic       ready
);
   int unsigned since_rst;
   int unsigned busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_rst <= 0;
         busy_run  <= 0;
      end else begin
         if (since_rst <= PWRUP_CYC + 1) since_rst <= since_rst + 1;
         if (ready) busy_run <= 0;
         else if (busy_run <= BUSY_CYC) busy_run <= busy_run + 1;
      end
   end

   AST_PWRUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst <= PWRUP_CYC) |-> ready); // R2

   AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= BUSY_CYC); // R3

   AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      bus_drive |-> ($past(!chip_sel_n) && $past(!rd_strobe_n))); // R9

   AST_QUIET_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_drive |-> (bus_out == 8'h00)); // R9

   if (SYNC_STAGES == 0) begin : g_direct_chk
      AST_BUSY_FROM_RESET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(ready) |-> ($past(cmd_sel) && $past(!chip_sel_n) && $past(wr_strobe_n)
                           && $past(bus_in) == 8'hFF)); // R3
   end
endmodule

bind nand_card_ctrl nand_card_ctrl_chk #(
   .PWRUP_CYC   (PWRUP_CYC),
   .BUSY_CYC    (BUSY_CYC),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .chip_sel_n  (chip_sel_n),
   .cmd_sel     (cmd_sel),
   .wr_strobe_n (wr_strobe_n),
   .rd_strobe_n (rd_strobe_n),
   .bus_in      (bus_in),
   .bus_out     (bus_out),
   .bus_drive   (bus_drive),
   .ready       (ready)
);

// File: tb/nand_card_ctrl_tb_top.sv
`timescale 1ns/1ps
module nand_card_ctrl_tb_top;
   localparam int unsigned PW  = 20;
   localparam int unsigned BZ  = 30;
   localparam logic [7:0]  DEV = 8'h75;
   localparam int          WD  = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       chip_sel_n = 1'b1, cmd_sel = 1'b0, addr_sel = 1'b0;
   logic       wr_strobe_n = 1'b1, rd_strobe_n = 1'b1, wr_lock_n = 1'b1;
   logic [7:0] bus_in = 8'h00;
   logic [7:0] bus_out;
   logic       bus_drive, ready;

   always #2 clk = ~clk;

   nand_card_ctrl #(.PWRUP_CYC(PW), .BUSY_CYC(BZ), .DEV_CODE(DEV)) dut_i (
      .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .cmd_sel(cmd_sel),
      .addr_sel(addr_sel), .wr_strobe_n(wr_strobe_n), .rd_strobe_n(rd_strobe_n),
      .wr_lock_n(wr_lock_n), .bus_in(bus_in), .bus_out(bus_out),
      .bus_drive(bus_drive), .ready(ready)
   );

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // behavioural reference model, advanced on every rising edge
   int   m_pu, m_busy, m_mode, m_idx;
   bit   m_wr_q, m_rd_q, e_drive, e_ready;
   logic [7:0] e_out;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pu = PW; m_busy = 0; m_mode = 0; m_idx = 0;
         m_wr_q = 1; m_rd_q = 1; e_drive = 0; e_out = 0; e_ready = 1;
      end else begin
         bit wr_up, rd_up, ok, rdy_now, on, take;
         logic [7:0] r;
         wr_up   = wr_strobe_n && !m_wr_q;
         rd_up   = rd_strobe_n && !m_rd_q;
         ok      = (m_pu == 0);
         rdy_now = (m_busy == 0);
         on = !chip_sel_n && !rd_strobe_n && (m_mode == 2 || m_mode == 3);
         if (m_mode == 3)      r = {wr_lock_n, rdy_now, 6'b0};
         else if (m_idx == 0)  r = 8'hEC;
         else if (m_idx == 1)  r = DEV;
         else                  r = 8'h00;
         e_drive = on;
         e_out   = on ? r : 8'h00;
         take = wr_up && !chip_sel_n && ok;
         if (take && cmd_sel && !addr_sel && bus_in == 8'hFF && rdy_now) m_busy = BZ;
         else if (m_busy > 0) m_busy--;
         if (m_pu > 0) m_pu--;
         if (rd_up && !chip_sel_n && m_mode == 2 && m_idx < 2) m_idx++;
         if (take && cmd_sel && !addr_sel) begin
            if (bus_in == 8'h90)      m_mode = 1;
            else if (bus_in == 8'h70) m_mode = 3;
            else                      m_mode = 0;
         end else if (take && addr_sel && !cmd_sel && m_mode == 1) begin
            if (bus_in == 8'h00) begin m_mode = 2; m_idx = 0; end
            else m_mode = 0;
         end
         m_wr_q = wr_strobe_n;
         m_rd_q = rd_strobe_n;
         e_ready = (m_busy == 0);
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R3 ready", ready, e_ready);
         chk("R9 drive", bus_drive, e_drive);
         chk("R5 or R7 data", bus_out, e_out);
      end
   end

   bit count_busy = 1'b0;
   int busy_seen  = 0;
   always @(negedge clk) if (count_busy && !ready) busy_seen++;

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc == WD && !done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=<%0d", cyc, WD);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic wr_byte(input bit is_cmd, input bit is_addr, input logic [7:0] b);
      @(negedge clk); cmd_sel = is_cmd; addr_sel = is_addr; bus_in = b; wr_strobe_n = 1'b0;
      @(negedge clk); wr_strobe_n = 1'b1;
      @(negedge clk); cmd_sel = 1'b0; addr_sel = 1'b0;
   endtask

   task automatic rd_byte(output bit drv, output logic [7:0] val);
      @(negedge clk); rd_strobe_n = 1'b0;
      @(negedge clk); drv = bus_drive; val = bus_out; rd_strobe_n = 1'b1;
      @(negedge clk);
   endtask

   bit         d;
   logic [7:0] v;

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 ready in reset", ready, 1);
      chk("R10 drive in reset", bus_drive, 0);
      chk("R10 out in reset", bus_out, 0);
      rst_n = 1'b1;
      chip_sel_n = 1'b0;
      @(negedge clk);
      chk("R10 ready after reset", ready, 1);

      // R2: writes during recovery are dropped
      wr_byte(1, 0, 8'hFF);
      chk("R2 reset cmd ignored", ready, 1);
      wr_byte(1, 0, 8'h70);
      rd_byte(d, v);
      chk("R2 status cmd ignored", d, 0);
      repeat (PW) @(negedge clk);

      // R7: status with write-protect off and on
      wr_byte(1, 0, 8'h70);
      rd_byte(d, v);
      chk("R7 status drive", d, 1);
      chk("R7 status unlocked", v, 8'hC0);
      wr_lock_n = 1'b0;
      rd_byte(d, v);
      chk("R7 status locked", v, 8'h40);
      wr_lock_n = 1'b1;

      // R1: deselected write is ignored; address outside ID arm ignored
      wr_byte(1, 0, 8'h55);
      chk("R8 unknown keeps ready", ready, 1);
      rd_byte(d, v);
      chk("R8 unknown leaves idle", d, 0);
      chip_sel_n = 1'b1;
      wr_byte(1, 0, 8'h70);
      chip_sel_n = 1'b0;
      rd_byte(d, v);
      chk("R1 deselected write dropped", d, 0);
      wr_byte(0, 1, 8'h00);
      rd_byte(d, v);
      chk("R1 stray address no effect", d, 0);

      // R5: ID sequence
      wr_byte(1, 0, 8'h90);
      wr_byte(0, 1, 8'h00);
      rd_byte(d, v);
      chk("R5 id first", v, 8'hEC);
      rd_byte(d, v);
      chk("R5 id second", v, DEV);
      rd_byte(d, v);
      chk("R5 id third", v, 8'h00);
      chk("R5 id third drive", d, 1);

      // R9: deselected read does not drive
      chip_sel_n = 1'b1;
      rd_byte(d, v);
      chip_sel_n = 1'b0;
      chk("R9 deselected read", d, 0);

      // R6: bad ID address
      wr_byte(1, 0, 8'h90);
      wr_byte(0, 1, 8'h01);
      rd_byte(d, v);
      chk("R6 bad address idle", d, 0);

      // R4: reset cancels armed ID read
      wr_byte(1, 0, 8'h90);
      wr_byte(0, 1, 8'h00);
      busy_seen = 0; count_busy = 1'b1;
      wr_byte(1, 0, 8'hFF);
      rd_byte(d, v);
      chk("R4 reset cancels id", d, 0);

      // R3: second reset while busy, status during busy
      chk("R3 busy after reset", ready, 0);
      wr_byte(1, 0, 8'hFF);
      wr_byte(1, 0, 8'h70);
      rd_byte(d, v);
      chk("R7 status while busy", v, 8'h80);
      for (int i = 0; i < 200 && !ready; i++) @(negedge clk);
      count_busy = 1'b0;
      chk("R3 busy length", busy_seen, BZ);
      rd_byte(d, v);
      chk("R7 status ready again", v, 8'hC0);

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule